// File: doc/BRIEF.md
# Indexed Frame Byte Buffer

This block holds the payload bytes of one serial bus frame for a LIN/UART controller. Eight bytes sit behind a single host data port. A small select register carries a 3-bit pointer. A host read or write on the data port touches the byte that the pointer names. A control bit in the select register chooses how the pointer behaves. With the bit clear, the pointer steps forward after every access and wraps from the last slot to the first. With the bit set, the pointer stays where it is, and software must write it again before the next access.

The frame engine reaches the same storage through a port of its own. That port uses a separate byte counter. A start pulse rewinds the counter to slot 0, so frame byte n always occupies slot n. Engine traffic never moves the host pointer.

In UART mode the storage and both pointers are not used. The host data port then acts as one unbuffered register pair. A host write sets the byte to be transmitted, and a host read returns the last byte the engine received.

Top module: `frame_byte_buffer`

## Requirements
- R1: After reset the select register reads 0: pointer 0, auto-step enabled. Every buffer byte reads 0.
- R2: The select register (host_addr=0) can be written and read back. Bits [2:0] hold the pointer and bit 3 holds the hold-pointer control. Bits [7:4] always read 0.
- R3: In LIN mode (uart_mode=0), a host write with host_addr=1 stores host_wdata in the slot the pointer names. With host_addr=1, host_rdata shows that slot's byte.
- R4: When bit 3 is 0, each host data access (read or write) advances the pointer by one. A write lands at the slot the pointer held before it advanced.
- R5: The pointer wraps from 7 to 0.
- R6: When bit 3 is 1, host data accesses leave the pointer unchanged.
- R7: eng_start sets the engine counter to 0 and ignores any other engine strobe in that cycle. eng_wr stores eng_wdata at the counter. eng_rdata shows the byte at the counter. Both eng_wr and eng_rd then advance the counter, which wraps from 7 to 0.
- R8: Engine activity (eng_start, eng_wr, eng_rd) never changes the host pointer.
- R9: In UART mode, a host data write loads the transmit byte, which appears on eng_rdata. eng_wr loads the receive byte, which a host data read returns. Neither the buffer nor the pointer changes.
- R10: When a host data write and an engine write hit the same slot in the same cycle, the host value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| uart_mode | input | 1 | 1 selects unbuffered UART operation |
| host_addr | input | 1 | 0 = select register, 1 = data port |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (counts as a data access) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| eng_start | input | 1 | Rewinds the engine counter to slot 0 |
| eng_wr | input | 1 | Engine write strobe |
| eng_rd | input | 1 | Engine read-advance strobe |
| eng_wdata | input | 8 | Engine write data |
| eng_rdata | output | 8 | Byte at the engine counter, or the transmit byte in UART mode |

## Verification
The hardest case to reach is a host write and an engine write landing on the same slot in the same cycle. The host pointer and the engine counter move independently, so the two must be steered together first. The bench does this by fixing the host pointer on slot 5 with the hold bit set. It then rewinds the engine and steps it five times with reads, and only then fires both writes in one cycle. The pointer wrap is covered in a similar way: auto-stepping write bursts start from each of the eight slots, so every slot is followed by its wrap-around neighbour.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
    typedef enum logic {
        REG_SEL  = 1'b0,
        REG_DATA = 1'b1
    } fbb_reg_e;
endpackage

// File: rtl/fbb_index.sv
// Host pointer and select register.
module fbb_index #(
    parameter int unsigned IDXW = 3,
    parameter int unsigned DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            uart_mode,
    input  logic            sel_wr,
    input  logic [DW-1:0]   sel_wdata,
    input  logic            data_acc,
    output logic [IDXW-1:0] idx,
    output logic            noinc,
    output logic [DW-1:0]   sel_rdata
);
    typedef struct packed {
        logic [IDXW-1:0] idx;
        logic            noinc;
    } idx_st_t;

    idx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_wr) begin
            st_d.idx   = sel_wdata[IDXW-1:0];
            st_d.noinc = sel_wdata[IDXW];
        end else if (data_acc && !uart_mode && !st_q.noinc) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        sel_rdata           = '0;
        sel_rdata[IDXW-1:0] = st_q.idx;
        sel_rdata[IDXW]     = st_q.noinc;
    end

    assign idx   = st_q.idx;
    assign noinc = st_q.noinc;
endmodule

// File: rtl/fbb_eng_ctr.sv
// Frame engine byte counter.
module fbb_eng_ctr #(
    parameter int unsigned IDXW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            step,
    output logic [IDXW-1:0] cnt
);
    typedef struct packed {
        logic [IDXW-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start)     st_d.cnt = '0;
        else if (step) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/fbb_store.sv
// Byte storage with two write ports; port A (host) wins on a shared slot.
module fbb_store #(
    parameter int unsigned IDXW = 3,
    parameter int unsigned DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            a_we,
    input  logic [IDXW-1:0] a_addr,
    input  logic [DW-1:0]   a_wdata,
    output logic [DW-1:0]   a_rdata,
    input  logic            b_we,
    input  logic [IDXW-1:0] b_addr,
    input  logic [DW-1:0]   b_wdata,
    output logic [DW-1:0]   b_rdata
);
    localparam int unsigned DEPTH = 1 << IDXW;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (b_we) st_d.mem[b_addr] = b_wdata;
        if (a_we) st_d.mem[a_addr] = a_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_rdata = st_q.mem[a_addr];
    assign b_rdata = st_q.mem[b_addr];
endmodule

// File: rtl/frame_byte_buffer.sv
module frame_byte_buffer #(
    parameter int unsigned IDXW = 3,
    parameter int unsigned DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uart_mode,
    input  logic          host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          eng_start,
    input  logic          eng_wr,
    input  logic          eng_rd,
    input  logic [DW-1:0] eng_wdata,
    output logic [DW-1:0] eng_rdata
);
    import fbb_pkg::*;

    typedef struct packed {
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
    } uart_st_t;

    uart_st_t        u_d, u_q;
    logic            data_sel;
    logic            data_acc;
    logic            sel_wr;
    logic            host_we;
    logic            eng_we;
    logic            eng_step;
    logic [IDXW-1:0] idx_w;
    logic            noinc_w;
    logic [IDXW-1:0] cnt_w;
    logic [DW-1:0]   sel_rdata;
    logic [DW-1:0]   host_buf_rdata;
    logic [DW-1:0]   eng_buf_rdata;

    always_comb begin
        data_sel = (host_addr == REG_DATA);
        data_acc = data_sel && (host_wr || host_rd);
        sel_wr   = !data_sel && host_wr;
        host_we  = !uart_mode && data_sel && host_wr;
        eng_we   = !uart_mode && eng_wr && !eng_start;
        eng_step = !uart_mode && (eng_wr || eng_rd);
    end

    fbb_index #(.IDXW(IDXW), .DW(DW)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .uart_mode (uart_mode),
        .sel_wr    (sel_wr),
        .sel_wdata (host_wdata),
        .data_acc  (data_acc),
        .idx       (idx_w),
        .noinc     (noinc_w),
        .sel_rdata (sel_rdata)
    );

    fbb_eng_ctr #(.IDXW(IDXW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .step  (eng_step),
        .cnt   (cnt_w)
    );

    fbb_store #(.IDXW(IDXW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (host_we),
        .a_addr  (idx_w),
        .a_wdata (host_wdata),
        .a_rdata (host_buf_rdata),
        .b_we    (eng_we),
        .b_addr  (cnt_w),
        .b_wdata (eng_wdata),
        .b_rdata (eng_buf_rdata)
    );

    // UART bypass registers
    always_comb begin
        u_d = u_q;
        if (uart_mode && data_sel && host_wr) u_d.tx = host_wdata;
        if (uart_mode && eng_wr)              u_d.rx = eng_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) u_q <= '0;
        else        u_q <= u_d;
    end

    always_comb begin
        if (!data_sel)      host_rdata = sel_rdata;
        else if (uart_mode) host_rdata = u_q.rx;
        else                host_rdata = host_buf_rdata;
        eng_rdata = uart_mode ? u_q.tx : eng_buf_rdata;
    end
endmodule

// File: rtl/fbb_checker.sv
module fbb_checker #(
    parameter int unsigned IDXW = 3,
    parameter int unsigned DW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            uart_mode,
    input logic            host_addr,
    input logic            host_wr,
    input logic            host_rd,
    input logic [DW-1:0]   host_wdata,
    input logic [DW-1:0]   host_rdata,
    input logic            eng_start,
    input logic            eng_wr,
    input logic            eng_rd,
    input logic [IDXW-1:0] idx,
    input logic            noinc,
    input logic [IDXW-1:0] eng_cnt
);
    import fbb_pkg::*;

    logic dacc;
    assign dacc = (host_addr == REG_DATA) && (host_wr || host_rd);

    AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == REG_SEL) |-> (host_rdata[DW-1:IDXW+1] == '0)); // R2
    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == REG_SEL && host_wr) |=>
        (idx == $past(host_wdata[IDXW-1:0]) && noinc == $past(host_wdata[IDXW]))); // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!uart_mode && dacc && !noinc) |=> (idx == $past(idx) + 1'b1)); // R4
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!uart_mode && dacc && !noinc && idx == '1) |=> (idx == '0)); // R5
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!uart_mode && dacc && noinc) |=> $stable(idx)); // R6
    AST_ENG_START: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> (eng_cnt == '0)); // R7
    AST_ENG_NO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !host_rd && (eng_start || eng_wr || eng_rd)) |=> $stable(idx)); // R8
    AST_UART_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_mode && dacc) |=> $stable(idx)); // R9
endmodule

bind frame_byte_buffer fbb_checker #(.IDXW(IDXW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .uart_mode  (uart_mode),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .eng_start  (eng_start),
    .eng_wr     (eng_wr),
    .eng_rd     (eng_rd),
    .idx        (idx_w),
    .noinc      (noinc_w),
    .eng_cnt    (cnt_w)
);

// File: tb/frame_byte_buffer_bench.sv
`timescale 1ns/1ps
module frame_byte_buffer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uart_mode = 1'b0;
    logic       host_addr = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       eng_start = 1'b0;
    logic       eng_wr = 1'b0;
    logic       eng_rd = 1'b0;
    logic [7:0] eng_wdata = '0;
    logic [7:0] eng_rdata;

    int n_chk = 0;
    int n_fail = 0;

    // reference model
    logic [7:0] mmem [8];
    logic [2:0] midx = '0;
    logic       mnoinc = 1'b0;
    logic [2:0] mcnt = '0;
    logic [7:0] mtx = '0;
    logic [7:0] mrx = '0;

    always #2 clk = ~clk;

    frame_byte_buffer u_frame_byte_buffer (
        .clk(clk), .rst_n(rst_n), .uart_mode(uart_mode),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_start(eng_start), .eng_wr(eng_wr), .eng_rd(eng_rd),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_wr = 0; host_rd = 0; eng_start = 0; eng_wr = 0; eng_rd = 0;
    endtask

    task automatic sel_write(input logic [7:0] v);
        @(negedge clk);
        host_addr = 0; host_wr = 1; host_wdata = v;
        @(negedge clk);
        idle();
        midx = v[2:0]; mnoinc = v[3];
    endtask

    task automatic sel_check(input string req);
        @(negedge clk);
        idle(); host_addr = 0;
        #1;
        chk(host_rdata == {4'b0, mnoinc, midx}, req, host_rdata, {4'b0, mnoinc, midx});
    endtask

    task automatic data_write(input logic [7:0] v);
        @(negedge clk);
        host_addr = 1; host_wr = 1; host_wdata = v;
        @(negedge clk);
        idle();
        if (uart_mode) mtx = v;
        else begin
            mmem[midx] = v;
            if (!mnoinc) midx = midx + 3'd1;
        end
    endtask

    task automatic data_read(input string req);
        logic [7:0] e;
        @(negedge clk);
        host_addr = 1; host_rd = 1;
        #1;
        e = uart_mode ? mrx : mmem[midx];
        chk(host_rdata == e, req, host_rdata, e);
        @(negedge clk);
        idle();
        if (!uart_mode && !mnoinc) midx = midx + 3'd1;
    endtask

    task automatic eng_go();
        @(negedge clk);
        eng_start = 1;
        @(negedge clk);
        idle();
        mcnt = '0;
    endtask

    task automatic eng_write(input logic [7:0] v);
        @(negedge clk);
        eng_wr = 1; eng_wdata = v;
        @(negedge clk);
        idle();
        if (uart_mode) mrx = v;
        else begin mmem[mcnt] = v; mcnt = mcnt + 3'd1; end
    endtask

    task automatic eng_read(input string req);
        logic [7:0] e;
        @(negedge clk);
        eng_rd = 1;
        #1;
        e = uart_mode ? mtx : mmem[mcnt];
        chk(eng_rdata == e, req, eng_rdata, e);
        @(negedge clk);
        idle();
        if (!uart_mode) mcnt = mcnt + 3'd1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state of select register and buffer
        sel_check("R1");
        for (int i = 0; i < 8; i++) data_read("R1");

        // R2: exhaustive select register write/readback, upper bits zero
        for (int v = 0; v < 256; v++) begin
            sel_write(v[7:0]);
            sel_check("R2");
        end

        // R3 R4 R5: auto-step bursts from every start slot
        for (int s = 0; s < 8; s++) begin
            sel_write(s[7:0]);
            for (int k = 0; k < 8; k++) data_write(8'((s * 16 + k * 3 + 1) & 255));
            sel_check("R5");
            for (int k = 0; k < 8; k++) data_read("R3");
            sel_check("R4");
        end

        // R6: hold-pointer mode, explicit pointer per access
        for (int i = 0; i < 8; i++) begin
            sel_write(8'(8 | i));
            data_write(8'(8'hC0 ^ (i * 7)));
            sel_check("R6");
            data_read("R6");
            data_read("R6");
            sel_check("R6");
        end

        // R7 R8: engine fills a frame, host pointer untouched
        sel_write(8'h03);
        eng_go();
        for (int k = 0; k < 8; k++) eng_write(8'(8'h40 + k * 5));
        sel_check("R8");
        sel_write(8'h00);
        for (int k = 0; k < 8; k++) data_read("R7");

        // R7: engine drains in order and wraps after slot 7
        for (int k = 0; k < 8; k++) data_write(8'(8'h90 + k));
        eng_go();
        for (int k = 0; k < 9; k++) eng_read("R7");
        eng_go();
        eng_read("R7");

        // R9: UART bypass
        uart_mode = 1;
        sel_write(8'h02);
        data_write(8'hA5);
        eng_read("R9");
        eng_write(8'h3C);
        data_read("R9");
        data_read("R9");
        sel_check("R9");
        uart_mode = 0;
        sel_write(8'h00);
        for (int k = 0; k < 8; k++) data_read("R9");

        // R10: simultaneous host and engine write to slot 5
        sel_write(8'h0D);
        eng_go();
        for (int k = 0; k < 5; k++) eng_read("R10");
        @(negedge clk);
        host_addr = 1; host_wr = 1; host_wdata = 8'h11;
        eng_wr = 1; eng_wdata = 8'h22;
        @(negedge clk);
        idle();
        mmem[5] = 8'h11; mcnt = mcnt + 3'd1;
        data_read("R10");
        eng_read("R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule